// File: doc/BRIEF.md
# Per-Trigger Veto Duration Recorder

This block times each veto contributor once for every accepted trigger. The contributors are the readout dead time, the charge-converter busy and the trigger pulse itself, plus the total veto formed as their OR. A trigger is accepted on the rising edge of the trigger input, and only while the block is idle. From the sampling edge of that trigger onward, four saturating counters each count the consecutive clock cycles in which their own signal is high. Each counter stops when its signal is first sampled low.

Once the total veto has fallen, every counter has stopped. The block then writes one 32-bit word per contributor into a word queue, which holds 4096 words by default. Each word carries a source tag in its top two bits and the duration below it. If the queue cannot take the whole set of four words, the set is discarded and a sticky overflow flag is raised.

A host empties the queue through a read strobe and a data output. It watches a status word that reports the fill count and four flags. The veto sources themselves are produced elsewhere and arrive here as plain inputs.

Top module: `veto_span_recorder`

## Requirements
- R1: After reset, the status word reads 0x0001_0000 (count 0, only the empty flag set) and the data output reads zero.
- R2: Each duration is the number of consecutive clock edges, counted from the edge that samples the trigger rising edge, at which the signal is sampled high. A signal that is low at that edge gives 0. The total duration applies the same rule to the OR of trigger, dead time and busy.
- R3: A duration saturates at 2^DUR_W-1 and never wraps.
- R4: Each set is written as four words, with the tag in bits 31:30 and the duration zero-extended in bits 29:0. The order is fixed: tag 0 trigger, then tag 1 dead time, then tag 2 busy, then tag 3 total.
- R5: A trigger rising edge that arrives while a measurement is still running or its words are still being written starts nothing and adds no words.
- R6: A set completes when the total veto is first sampled low. If the fill count then exceeds DEPTH-4, all four words are dropped and the overflow flag is set.
- R7: The overflow flag stays set until the clear input is pulsed. The clear input lowers it.
- R8: A read strobe on a non-empty queue pops the oldest word. The word appears on the data output after the next clock edge, and the count drops by one.
- R9: A read strobe on an empty queue drives the data output to zero and leaves the count and flags unchanged.
- R10: The status word packs the fields as follows; all other bits are zero:
  - bits 12:0: fill count
  - bit 16: empty
  - bit 17: full (count equals DEPTH)
  - bit 18: almost-full (count at least DEPTH-AF_MARGIN)
  - bit 19: overflow
- R11: A write and a pop in the same clock cycle both take effect. The count is left unchanged and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Trigger pulse; its rising edge starts a measurement |
| dead_i | input | 1 | Readout dead-time level |
| busy_i | input | 1 | Charge-converter busy level |
| rd_i | input | 1 | Read strobe, one word per cycle held high |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| rd_data_o | output | 32 | Word popped by the last read strobe |
| status_o | output | 32 | Fill count and flags |

## Verification
The host can pop a word in the same cycle that the recorder pushes one of the four words of a new set. The count must then stay put, and the read order must still follow the write order. The bench provokes this by preloading two sets and then triggering again. It holds the read strobe high for six cycles, placed over the window in which the four writes of the new set land, and compares every popped word with its own queue model. Afterwards it compares the fill count with the count predicted as preload minus pops plus four, and drains the queue to check that the new set arrived complete and in order.

// File: rtl/dtrec_pkg.sv
package dtrec_pkg;
  localparam int NUM_SRC = 4;
  localparam int WORD_W  = 32;
  localparam int TAG_W   = 2;
  localparam int STAT_CNT_W = 13;

  // tag value equals write position within a set
  typedef enum logic [TAG_W-1:0] {
    SRC_TRIG  = 2'd0,
    SRC_DEAD  = 2'd1,
    SRC_BUSY  = 2'd2,
    SRC_TOTAL = 2'd3
  } src_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_EMIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/dtrec_rst_sync.sv
module dtrec_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/dtrec_span_ctr.sv
module dtrec_span_ctr #(
  parameter int DUR_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             level_i,
  output logic [DUR_W-1:0] dur_o,
  output logic             active_o
);
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  logic             active_q, active_d;
  logic [DUR_W-1:0] dur_q, dur_d;
  logic             en;

  assign en = start_i | active_q;

  always_comb begin
    active_d = active_q;
    dur_d    = dur_q;
    if (start_i) begin
      active_d = level_i;
      dur_d    = {{(DUR_W-1){1'b0}}, level_i};
    end else if (active_q) begin
      if (!level_i)              active_d = 1'b0;
      else if (dur_q != DUR_MAX) dur_d    = dur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dur_q    <= '0;
    end else if (en) begin
      active_q <= active_d;
      dur_q    <= dur_d;
    end
  end

  assign dur_o    = dur_q;
  assign active_o = active_q;
endmodule

// File: rtl/dtrec_fifo.sv
module dtrec_fifo #(
  parameter int DEPTH  = 4096,
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [WORD_W-1:0] rd_data_q, rd_data_d;
  logic              push, pop, en;

  assign push = wr_en_i && (count_q != FULL_LVL);
  assign pop  = rd_en_i && (count_q != '0);
  assign en   = push | rd_en_i;

  always_comb begin
    wptr_d    = push ? wptr_q + 1'b1 : wptr_q;
    rptr_d    = pop  ? rptr_q + 1'b1 : rptr_q;
    count_d   = count_q;
    if (push && !pop)      count_d = count_q + 1'b1;
    else if (pop && !push) count_d = count_q - 1'b1;
    rd_data_d = rd_data_q;
    if (rd_en_i) rd_data_d = pop ? mem[rptr_q] : '0;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      count_q   <= '0;
      rd_data_q <= '0;
    end else if (en) begin
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_d;
      count_q   <= count_d;
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data_o = rd_data_q;
  assign count_o   = count_q;
endmodule

// File: rtl/veto_span_recorder.sv
module veto_span_recorder
  import dtrec_pkg::*;
#(
  parameter int DEPTH     = 4096,
  parameter int DUR_W     = 30,
  parameter int AF_MARGIN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_i,
  input  logic        dead_i,
  input  logic        busy_i,
  input  logic        rd_i,
  input  logic        ovf_clr_i,
  output logic [31:0] rd_data_o,
  output logic [31:0] status_o
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] DROP_LVL = CNT_W'(DEPTH - NUM_SRC);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AF_LVL   = CNT_W'(DEPTH - AF_MARGIN);

  logic rst_sync_n;
  dtrec_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  ctl_state_e         state_q, state_d;
  logic [TAG_W-1:0]   idx_q, idx_d;
  logic               trig_q, ovf_q, ovf_d, ovf_set;
  logic               start, all_idle, idx_en;
  logic               fifo_wr;
  logic [WORD_W-1:0]  fifo_wdata;
  logic [CNT_W-1:0]   fill;
  logic [NUM_SRC-1:0] lvl, active;
  logic [DUR_W-1:0]   dur [NUM_SRC];

  // index order matches tag value: trigger, dead, busy, total
  assign lvl      = {trig_i | dead_i | busy_i, busy_i, dead_i, trig_i};
  assign start    = (state_q == ST_IDLE) && trig_i && !trig_q;
  assign all_idle = ~|active;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_span
    dtrec_span_ctr #(.DUR_W(DUR_W)) u_span (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .start_i  (start),
      .level_i  (lvl[g]),
      .dur_o    (dur[g]),
      .active_o (active[g])
    );
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    fifo_wr = 1'b0;
    ovf_set = 1'b0;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_MEAS;
      ST_MEAS: if (all_idle) begin
        if (fill > DROP_LVL) begin
          ovf_set = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_EMIT;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_EMIT: begin
        fifo_wr = 1'b1;
        idx_d   = idx_q + 1'b1;
        idx_en  = 1'b1;
        if (idx_q == TAG_W'(NUM_SRC - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    ovf_d = ovf_q;
    if (ovf_set)        ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
  end

  assign fifo_wdata = {idx_q, (WORD_W-TAG_W)'(dur[idx_q])};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      trig_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_i;
      ovf_q   <= ovf_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  dtrec_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (fifo_wr),
    .wr_data_i (fifo_wdata),
    .rd_en_i   (rd_i),
    .rd_data_o (rd_data_o),
    .count_o   (fill)
  );

  always_comb begin
    status_o        = '0;
    status_o[12:0]  = STAT_CNT_W'(fill);
    status_o[16]    = (fill == '0);
    status_o[17]    = (fill == FULL_LVL);
    status_o[18]    = (fill >= AF_LVL);
    status_o[19]    = ovf_q;
  end
endmodule

// File: rtl/veto_span_recorder_chk.sv
module veto_span_recorder_chk #(
  parameter int DEPTH = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_i,
  input logic        ovf_clr_i,
  input logic        wr_en,
  input logic [31:0] status_o
);
  localparam logic [12:0] DEPTH_C = 13'(DEPTH);
  logic [12:0] cnt;
  logic        empty, full, ovf;
  assign cnt   = status_o[12:0];
  assign empty = status_o[16];
  assign full  = status_o[17];
  assign ovf   = status_o[19];

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= DEPTH_C);
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr_i) |=> ovf);
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && empty && !wr_en) |=> $stable(cnt));
  // R11
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && wr_en && !empty && !full) |=> $stable(cnt));
  // R6
  no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
  // R8
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !empty && !wr_en) |=> (cnt == $past(cnt) - 13'd1));
endmodule

bind veto_span_recorder veto_span_recorder_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_i      (rd_i),
  .ovf_clr_i (ovf_clr_i),
  .wr_en     (fifo_wr),
  .status_o  (status_o)
);

// File: tb/veto_span_recorder_bench.sv
module veto_span_recorder_bench;
  localparam int DEPTH = 32, DUR_W = 6, AF_MARGIN = 8;
  localparam int DMAX = (1 << DUR_W) - 1;

  typedef struct {
    int tl, t2s, t2l, ds, dl, bs, bl;
  } pat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 1'b0, dead = 1'b0, busy = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [31:0] rdata, status;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  bit exp_ovf = 1'b0;

  always #2.5 clk = ~clk;

  veto_span_recorder #(.DEPTH(DEPTH), .DUR_W(DUR_W), .AF_MARGIN(AF_MARGIN)) u_veto_span_recorder (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .dead_i(dead), .busy_i(busy),
    .rd_i(rd), .ovf_clr_i(clr), .rd_data_o(rdata), .status_o(status));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    int c = exp_q.size();
    s[12:0] = 13'(c);
    s[16] = (c == 0);
    s[17] = (c == DEPTH);
    s[18] = (c >= DEPTH - AF_MARGIN);
    s[19] = exp_ovf;
    return s;
  endfunction

  function automatic bit inwin(int i, int s, int l);
    return (i >= s) && (i < s + l);
  endfunction

  function automatic bit sig_at(pat_t p, int src, int i);
    bit t = inwin(i, 0, p.tl) || inwin(i, p.t2s, p.t2l);
    bit d = inwin(i, p.ds, p.dl);
    bit b = inwin(i, p.bs, p.bl);
    case (src)
      0: return t;
      1: return d;
      2: return b;
      default: return t | d | b;
    endcase
  endfunction

  function automatic int exp_dur(pat_t p, int src);
    int n = 0;
    while (sig_at(p, src, n)) n++;
    return (n > DMAX) ? DMAX : n;
  endfunction

  function automatic int pat_end(pat_t p);
    int e = p.tl;
    if (p.t2s + p.t2l > e) e = p.t2s + p.t2l;
    if (p.ds + p.dl > e) e = p.ds + p.dl;
    if (p.bs + p.bl > e) e = p.bs + p.bl;
    return e;
  endfunction

  task automatic apply(pat_t p);
    int last = pat_end(p);
    for (int i = -3; i <= last + 1; i++) begin
      @(negedge clk);
      trig = sig_at(p, 0, i);
      dead = sig_at(p, 1, i);
      busy = sig_at(p, 2, i);
    end
    repeat (12) @(negedge clk);
    if (exp_q.size() > DEPTH - 4) exp_ovf = 1'b1;
    else for (int s = 0; s < 4; s++) exp_q.push_back({2'(s), 30'(exp_dur(p, s))});
  endtask

  task automatic pop_check(string req);
    logic [31:0] e;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
    check(req, rdata, e);
  endtask

  task automatic drain(string req);
    while (exp_q.size() > 0) pop_check(req);
    check(req, status, exp_status());
  endtask

  function automatic pat_t mk(int tl, int ds, int dl, int bs, int bl);
    pat_t p;
    p.tl = tl; p.t2s = 0; p.t2l = 0;
    p.ds = ds; p.dl = dl; p.bs = bs; p.bl = bl;
    return p;
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    pat_t p;
    void'($urandom(32'd917));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 status", status, 32'h0001_0000);
    check("R1 data", rdata, 32'h0);

    // R9 empty read
    pop_check("R9 empty data");
    check("R9 empty status", status, exp_status());

    // R2 R4 busy low at trigger gives 0
    apply(mk(3, 0, 7, 1, 4));
    check("R10 status one set", status, exp_status());
    drain("R2 R4 set A");

    // R2 dead already high before trigger
    apply(mk(1, -2, 5, 0, 10));
    drain("R2 set B");

    // R3 saturation
    apply(mk(2, 0, 100, 0, 3));
    drain("R3 saturate");

    // R2 total stops at first low even if dead rises later
    apply(mk(2, 3, 4, 0, 0));
    drain("R2 gap");

    // R5 second trigger edge during measurement
    p = mk(2, 0, 10, 0, 0); p.t2s = 5; p.t2l = 2;
    apply(p);
    check("R5 single set", status, exp_status());
    drain("R5 words");

    // random patterns
    for (int k = 0; k < 20; k++) begin
      p = mk(1 + int'($urandom_range(4)), int'($urandom_range(5)) - 2,
             int'($urandom_range(12)), int'($urandom_range(4)), int'($urandom_range(10)));
      apply(p);
      if (k % 3 == 2) drain("R2 R4 R8 random");
    end
    drain("R8 random tail");

    // fill, full and almost-full
    for (int k = 0; k < 8; k++) begin
      apply(mk(1 + k % 3, 0, k, 0, 0));
      check("R10 fill status", status, exp_status());
    end
    apply(mk(1, 0, 2, 0, 0));
    check("R6 drop when full", status, exp_status());
    repeat (3) pop_check("R8 partial");
    check("R7 sticky after reads", status, exp_status());
    apply(mk(1, 0, 2, 0, 0));
    check("R6 drop with 3 free", status, exp_status());
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_ovf = 1'b0;
    check("R7 clear", status, exp_status());
    pop_check("R8 after drop");
    apply(mk(2, 0, 3, 0, 1));
    check("R6 accepted with 4 free", status, exp_status());
    drain("R8 drain full");

    // R11 pop and push in the same cycles
    apply(mk(1, 0, 2, 0, 0));
    apply(mk(2, 0, 1, 0, 0));
    p = mk(1, 0, 6, 0, 3);
    fork
      apply(p);
      begin
        repeat (exp_dur(p, 3) + 4) @(negedge clk);
        rd = 1'b1;
        for (int j = 0; j < 6; j++) begin
          @(negedge clk);
          check("R11 overlap data", rdata, exp_q.pop_front());
        end
        rd = 1'b0;
      end
    join
    check("R11 count", status, exp_status());
    drain("R11 drain");
    pop_check("R9 final empty");
    check("R9 final status", status, exp_status());
    report();
  end
endmodule